// File: doc/BRIEF.md
# Two-Channel Reloadable Down-Counter Timer

A memory-mapped timer with independent down-counting channels (two by default, 32 bits wide). Each channel keeps a reload value (the fixed count) and a live counter (the running count). A per-channel tick source picks between counting on every clock, counting on a slow reference strobe, or not counting. When the running count reaches zero, the channel raises a sticky flag. It then reloads from the fixed count, or it stops, depending on the reload bit. Software can arm a one-shot deadline in a single write: with the update bit set, a write to the fixed count also loads the running count. Software measures elapsed time as the inverse of a free-running channel's running count.

Each channel has a state machine with three states. ST_IDLE is entered at reset and while the block-wide hold bit is set. ST_RUN is the counting state. ST_DONE is the stopped-at-zero state. The transitions are:

- arm: from any state to ST_RUN, on a fixed-count write with update set.
- expire: from ST_RUN to ST_DONE, on reaching zero with reload off.
- wrap: from ST_RUN to ST_RUN, reloading at zero with reload on.
- restart: from ST_IDLE or ST_DONE to ST_RUN, on a tick with reload on; the running count loads the fixed count.
- clear: from any state to ST_IDLE, while hold is set.

Registers are reached over a simple synchronous bus. The bus takes a write strobe and returns read data combinationally from the address. A channel's interrupt output is high while its flag and its interrupt enable are both set.

Top module: `tmr_block`

## Requirements
- R1: After reset, all registers read zero except the version register at 0xF0. That register reads 0x0200_0000, with major version 2 in bits [31:24]. All irq outputs are low. Unmapped addresses read zero.
- R2: Channel control bits [3:0] select the tick source: 0xF ticks every clock, 0xB ticks on cycles where slow_tick is high, and any other value never ticks. In ST_RUN each tick lowers a nonzero running count by exactly one.
- R3: With reload (control bit 6) set, a tick at running count zero loads the fixed count. A free-running channel with fixed count F therefore repeats every F+1 ticks.
- R4: With update (control bit 7) set, a write to the fixed count also loads the written value into the running count at the same clock edge.
- R5: The flag (control bit 15) is set when a tick brings the running count to zero. It stays set until software clears it. irq[n] is high exactly when bit 15 and bit 14 (interrupt enable) are both set.
- R6: With reload clear, a channel that reaches zero stays at zero, whatever the ticks, until an update write re-arms it.
- R7: Every register has write aliases at +0x4 (set the written ones), +0x8 (clear the written ones) and +0xC (toggle the written ones). A read at any alias returns the base register. Channel n places control at 0x20+n*0x40, running count at 0x30+n*0x40 and fixed count at 0x40+n*0x40. The block control sits at 0x00.
- R8: If a tick brings the count to zero in the same cycle that software clears the flag, the flag ends up set.
- R9: Writes to the running count address, at any alias, have no effect.
- R10: Block control bit 30 freezes all channels (no ticks). Block control bit 31 holds every channel in ST_IDLE, with running count zero and flag clear.
- R11: An update load takes priority over a tick in the same cycle: the running count equals the written value, not the written value minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle strobe of the slow reference |
| bus_we | input | 1 | Write strobe for bus_addr / bus_wdata |
| bus_addr | input | 8 | Byte address; bits [3:2] select the alias |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 2 | Per-channel interrupt, flag AND enable |

## Verification
Two events can land on the same clock edge. In the first, the hardware sets the flag as the count reaches zero while a software clear-alias write to that flag arrives. In the second, an update write to the fixed count arrives together with a tick that would decrement. Directed sequences time the clear write and the update write to fall on exactly the expiring or ticking edge. The flag must then read set, and the running count must read the written value. Random traffic from a fixed seed mixes alias writes, tick-source changes and slow strobes. A per-cycle reference model in the bench checks every register read and every irq sample against its predictions.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        OP_WR  = 2'd0,
        OP_SET = 2'd1,
        OP_CLR = 2'd2,
        OP_TOG = 2'd3
    } wr_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ch_state_e;

    localparam int BIT_RELOAD = 6;
    localparam int BIT_UPDATE = 7;
    localparam int BIT_IE     = 14;
    localparam int BIT_FLAG   = 15;
    localparam int BIT_FREEZE = 30;
    localparam int BIT_HOLD   = 31;

    localparam logic [3:0]  SEL_ALWAYS = 4'hF;
    localparam logic [3:0]  SEL_SLOW   = 4'hB;
    localparam logic [31:0] CTRL_MASK  = 32'h0000_C0CF;
    localparam logic [31:0] BLK_MASK   = 32'hC000_0000;

    function automatic logic [31:0] wmerge(input wr_op_e op,
                                           input logic [31:0] cur,
                                           input logic [31:0] wd);
        logic [31:0] r;
        unique case (op)
            OP_WR:   r = wd;
            OP_SET:  r = cur | wd;
            OP_CLR:  r = cur & ~wd;
            OP_TOG:  r = cur ^ wd;
            default: r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
    import tmr_pkg::*;
(
    input  logic [3:0] sel,
    input  logic       slow_tick,
    input  logic       freeze,
    output logic       tick
);

    always_comb begin
        tick = 1'b0;
        if (!freeze) begin
            if (sel == SEL_ALWAYS)
                tick = 1'b1;
            else if (sel == SEL_SLOW)
                tick = slow_tick;
        end
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_clr,
    input  logic             freeze,
    input  logic             slow_tick,
    input  logic             ctrl_we,
    input  logic [31:0]      ctrl_wval,
    input  logic             fix_we,
    input  logic [CNT_W-1:0] fix_wval,
    output logic [31:0]      ctrl_q,
    output logic [CNT_W-1:0] fix_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             irq
);

    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    ch_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_d, fix_d;
    logic [31:0]      ctl_d;
    logic             tick, load, hit, reload;

    tmr_tick_sel u_tick (
        .sel       (ctrl_q[3:0]),
        .slow_tick (slow_tick),
        .freeze    (freeze),
        .tick      (tick)
    );

    assign reload = ctrl_q[BIT_RELOAD];
    assign load   = fix_we && ctrl_q[BIT_UPDATE];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            fix_q  <= '0;
            ctrl_q <= '0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            fix_q  <= fix_d;
            ctrl_q <= ctl_d;
        end
    end

    // Next state and counter
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        hit   = 1'b0;
        if (hold_clr) begin
            st_d  = ST_IDLE;
            cnt_d = ZERO;
        end else if (load) begin
            st_d  = ST_RUN;
            cnt_d = fix_wval;
        end else if (tick) begin
            unique case (st_q)
                ST_RUN: begin
                    if (cnt_q > ONE) begin
                        cnt_d = cnt_q - ONE;
                    end else if (cnt_q == ONE) begin
                        cnt_d = ZERO;
                        hit   = 1'b1;
                        if (!reload) st_d = ST_DONE;
                    end else if (reload) begin
                        cnt_d = fix_q;
                        hit   = (fix_q == ZERO);
                    end else begin
                        hit  = 1'b1;
                        st_d = ST_DONE;
                    end
                end
                ST_IDLE, ST_DONE: begin
                    if (reload) begin
                        cnt_d = fix_q;
                        st_d  = ST_RUN;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // Register contents and outputs
    always_comb begin
        ctl_d = ctrl_we ? (ctrl_wval & CTRL_MASK) : ctrl_q;
        if (hold_clr)
            ctl_d[BIT_FLAG] = 1'b0;
        else if (hit)
            ctl_d[BIT_FLAG] = 1'b1;
        fix_d = fix_we ? fix_wval : fix_q;
        irq   = ctrl_q[BIT_FLAG] & ctrl_q[BIT_IE];
    end

    p_dec_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && tick && !load && !hold_clr && cnt_q > ONE)
        |=> (cnt_q == $past(cnt_q) - ONE));

    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && tick && reload && cnt_q == ZERO && !load && !hold_clr)
        |=> (cnt_q == $past(fix_q)));

    p_update_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !hold_clr) |=> (cnt_q == $past(fix_wval)));

    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[BIT_FLAG] && !ctrl_we && !hold_clr) |=> ctrl_q[BIT_FLAG]);

    p_stop_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DONE && !hold_clr && !load && !(tick && reload))
        |=> $stable(cnt_q));

    p_hit_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !hold_clr) |=> ctrl_q[BIT_FLAG]);

    p_hold_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hold_clr |=> (cnt_q == ZERO && !ctrl_q[BIT_FLAG] && st_q == ST_IDLE));

endmodule

// File: rtl/tmr_block.sv
module tmr_block
    import tmr_pkg::*;
#(
    parameter int NUM_CH    = 2,
    parameter int CNT_W     = 32,
    parameter int ADDR_W    = 8,
    parameter int VER_MAJOR = 2,
    parameter int VER_OFS   = 'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    localparam int          CH_STRIDE = 'h40;
    localparam int          OFS_CTRL  = 'h20;
    localparam int          OFS_RUN   = 'h30;
    localparam int          OFS_FIX   = 'h40;
    localparam logic [31:0] VER_VAL   = 32'(VER_MAJOR) << 24;

    function automatic logic [ADDR_W-1:0] ch_ofs(input int base_ofs, input int ch);
        return ADDR_W'(base_ofs + ch * CH_STRIDE);
    endfunction

    wr_op_e            op;
    logic [ADDR_W-1:0] base;
    logic [31:0]       blk_q;

    logic [31:0]      ch_ctrl [NUM_CH];
    logic [CNT_W-1:0] ch_fix  [NUM_CH];
    logic [CNT_W-1:0] ch_cnt  [NUM_CH];

    assign op   = wr_op_e'(bus_addr[3:2]);
    assign base = {bus_addr[ADDR_W-1:4], 4'b0000};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            blk_q <= '0;
        else if (bus_we && base == '0)
            blk_q <= wmerge(op, blk_q, bus_wdata) & BLK_MASK;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic        ctrl_we, fix_we;
        logic [31:0] ctrl_wval, fix_full;

        assign ctrl_we   = bus_we && (base == ch_ofs(OFS_CTRL, g));
        assign fix_we    = bus_we && (base == ch_ofs(OFS_FIX, g));
        assign ctrl_wval = wmerge(op, ch_ctrl[g], bus_wdata);
        assign fix_full  = wmerge(op, 32'(ch_fix[g]), bus_wdata);

        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .hold_clr  (blk_q[BIT_HOLD]),
            .freeze    (blk_q[BIT_FREEZE]),
            .slow_tick (slow_tick),
            .ctrl_we   (ctrl_we),
            .ctrl_wval (ctrl_wval),
            .fix_we    (fix_we),
            .fix_wval  (fix_full[CNT_W-1:0]),
            .ctrl_q    (ch_ctrl[g]),
            .fix_q     (ch_fix[g]),
            .cnt_q     (ch_cnt[g]),
            .irq       (irq[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (base == '0)
            bus_rdata = blk_q;
        else if (base == ADDR_W'(VER_OFS))
            bus_rdata = VER_VAL;
        for (int i = 0; i < NUM_CH; i++) begin
            if (base == ch_ofs(OFS_CTRL, i)) bus_rdata = ch_ctrl[i];
            if (base == ch_ofs(OFS_RUN, i))  bus_rdata = 32'(ch_cnt[i]);
            if (base == ch_ofs(OFS_FIX, i))  bus_rdata = 32'(ch_fix[i]);
        end
    end

    p_irq_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq[0] |-> ch_ctrl[0][BIT_FLAG]));

endmodule

// File: tb/tb_tmr_block.sv
`timescale 1ns/100ps
module tb_tmr_block;

    localparam int NCH = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        slow_tick;
    logic        bus_we;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    always #5 clk = ~clk;

    tmr_block dut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    logic [31:0] m_blk;
    logic [31:0] m_ctrl [NCH];
    logic [31:0] m_fix  [NCH];
    logic [31:0] m_cnt  [NCH];
    bit          m_run  [NCH];

    function automatic logic [31:0] apply(input logic [1:0] op, input logic [31:0] cur, input logic [31:0] wd);
        case (op)
            2'd0: return wd;
            2'd1: return cur | wd;
            2'd2: return cur & ~wd;
            default: return cur ^ wd;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        logic [7:0] b;
        b = a & 8'hF0;
        if (b == 8'h00) return m_blk;
        if (b == 8'hF0) return 32'h0200_0000;
        for (int n = 0; n < NCH; n++) begin
            if (b == 8'(8'h20 + n * 64)) return m_ctrl[n];
            if (b == 8'(8'h30 + n * 64)) return m_cnt[n];
            if (b == 8'(8'h40 + n * 64)) return m_fix[n];
        end
        return 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        end
        $finish;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        bus_we = 1'b0;
        bus_addr = a;
        #0.4;
        chk(tag, bus_rdata, exp_read(a));
    endtask

    task automatic rdx(input logic [7:0] a, input string tag, input logic [31:0] exp);
        bus_we = 1'b0;
        bus_addr = a;
        #0.4;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic check_all(input string tag);
        rd(8'h00, {tag, " R10 blk"});
        rd(8'hF0, {tag, " R1 ver"});
        for (int n = 0; n < NCH; n++) begin
            rd(8'(8'h20 + n * 64), {tag, " R7 ctrl"});
            rd(8'(8'h30 + n * 64), {tag, " R2 run"});
            rd(8'(8'h40 + n * 64), {tag, " R4 fix"});
        end
    endtask

    // One clock: drive at negedge, predict, commit after posedge, check irq at next negedge.
    task automatic step(input logic we, input logic [7:0] a, input logic [31:0] wd, input logic slow);
        logic [31:0] nblk;
        logic [31:0] nc [NCH];
        logic [31:0] nf [NCH];
        logic [31:0] ncnt [NCH];
        bit          nrun [NCH];
        logic [7:0]  b;
        logic [1:0]  op;
        bus_we = we; bus_addr = a; bus_wdata = wd; slow_tick = slow;
        b = a & 8'hF0;
        op = a[3:2];
        nblk = m_blk;
        if (we && b == 8'h00) nblk = apply(op, m_blk, wd) & 32'hC000_0000;
        for (int n = 0; n < NCH; n++) begin
            logic [31:0] c;
            logic tk, ld, hit;
            c = m_ctrl[n];
            nc[n] = c; nf[n] = m_fix[n]; ncnt[n] = m_cnt[n]; nrun[n] = m_run[n];
            hit = 1'b0;
            tk = !m_blk[30] && (c[3:0] == 4'hF || (c[3:0] == 4'hB && slow));
            if (we && b == 8'(8'h20 + n * 64)) nc[n] = apply(op, c, wd) & 32'h0000_C0CF;
            if (we && b == 8'(8'h40 + n * 64)) nf[n] = apply(op, m_fix[n], wd);
            ld = we && (b == 8'(8'h40 + n * 64)) && c[7];
            if (m_blk[31]) begin
                ncnt[n] = 0; nrun[n] = 0;
            end else if (ld) begin
                ncnt[n] = nf[n]; nrun[n] = 1;
            end else if (tk) begin
                if (m_run[n]) begin
                    if (m_cnt[n] > 1) ncnt[n] = m_cnt[n] - 1;
                    else if (m_cnt[n] == 1) begin
                        ncnt[n] = 0; hit = 1'b1;
                        if (!c[6]) nrun[n] = 0;
                    end else if (c[6]) begin
                        ncnt[n] = m_fix[n]; hit = (m_fix[n] == 0);
                    end else begin
                        hit = 1'b1; nrun[n] = 0;
                    end
                end else if (c[6]) begin
                    ncnt[n] = m_fix[n]; nrun[n] = 1;
                end
            end
            if (m_blk[31]) nc[n][15] = 1'b0;
            else if (hit) nc[n][15] = 1'b1;
        end
        @(posedge clk);
        m_blk = nblk;
        for (int n = 0; n < NCH; n++) begin
            m_ctrl[n] = nc[n]; m_fix[n] = nf[n]; m_cnt[n] = ncnt[n]; m_run[n] = nrun[n];
        end
        #1 bus_we = 1'b0;
        @(negedge clk);
        for (int n = 0; n < NCH; n++)
            chk("R5 irq", {31'b0, irq[n]}, {31'b0, m_ctrl[n][15] & m_ctrl[n][14]});
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step(1'b0, 8'h00, 32'h0, 1'b0);
    endtask

    initial begin
        #2_000_000;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] keep;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; slow_tick = 1'b0;
        m_blk = '0;
        for (int n = 0; n < NCH; n++) begin
            m_ctrl[n] = '0; m_fix[n] = '0; m_cnt[n] = '0; m_run[n] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("reset");
        rdx(8'hF0, "R1 version", 32'h0200_0000);
        rdx(8'hB4, "R1 unmapped", 32'h0);
        chk("R1 irq", {30'b0, irq}, 32'h0);

        // R4: update load with no tick source
        step(1, 8'h20, 32'h80, 0);
        step(1, 8'h40, 32'd5, 0);
        rdx(8'h30, "R4 update load", 32'd5);
        // R2: select every-clock via set alias
        step(1, 8'h24, 32'hF, 0);
        rdx(8'h30, "R2 no tick before select", 32'd5);
        idle(1);
        rdx(8'h30, "R2 decrement", 32'd4);
        idle(2);
        rdx(8'h30, "R2 decrement", 32'd2);
        // R8: clear flag on the expiring edge
        idle(1);
        step(1, 8'h28, 32'h8000, 0);
        rdx(8'h20, "R8 hit beats clear", 32'h0000_808F);
        idle(3);
        rdx(8'h30, "R6 stays at zero", 32'd0);
        // R7 aliases
        step(1, 8'h28, 32'h8000, 0);
        rdx(8'h20, "R7 clear alias", 32'h0000_008F);
        rdx(8'h2C, "R7 alias read", 32'h0000_008F);
        step(1, 8'h2C, 32'h4000, 0);
        rdx(8'h20, "R7 toggle alias", 32'h0000_408F);
        // R11 load beats tick; R5 flag and irq
        step(1, 8'h40, 32'd3, 0);
        rdx(8'h30, "R11 load over tick", 32'd3);
        idle(3);
        chk("R5 irq raised", {31'b0, irq[0]}, 32'd1);
        idle(2);
        chk("R5 irq sticky", {31'b0, irq[0]}, 32'd1);
        // R3 reload
        step(1, 8'h24, 32'h40, 0);
        step(1, 8'h28, 32'h8000, 0);
        rdx(8'h30, "R3 restart loads fixed", 32'd3);
        bus_addr = 8'h30; #0.4 keep = bus_rdata;
        idle(4);
        rdx(8'h30, "R3 period F+1", keep);
        check_all("R3");
        // R9 running count is read-only
        step(1, 8'h30, 32'h1234, 0);
        step(1, 8'h34, 32'hFFFF, 0);
        check_all("R9");
        // R10 freeze and hold
        step(1, 8'h04, 32'h4000_0000, 0);
        bus_addr = 8'h30; #0.4 keep = bus_rdata;
        idle(3);
        rdx(8'h30, "R10 freeze", keep);
        step(1, 8'h04, 32'h8000_0000, 0);
        idle(1);
        rdx(8'h30, "R10 hold count", 32'd0);
        check_all("R10");
        step(1, 8'h00, 32'h0, 0);
        // R2 slow source on channel 1
        step(1, 8'h60, 32'hCB, 0);
        step(1, 8'h80, 32'd2, 0);
        for (int i = 0; i < 10; i++) begin
            step(0, 8'h00, 32'h0, 1'(i % 3 == 0));
            rd(8'h70, "R2 slow tick");
            rd(8'h60, "R5 slow flag");
        end

        // Random traffic
        for (int it = 0; it < 4000; it++) begin
            int r, kind, ch;
            logic [7:0] a;
            logic [31:0] d;
            r = int'($urandom % 10);
            kind = int'($urandom % 16);
            ch = int'($urandom % NCH);
            a = 8'(($urandom % 4) * 4);
            d = $urandom;
            if (kind < 6) begin
                a = a + 8'(8'h20 + ch * 64);
                case ($urandom % 4)
                    0: d = (d & 32'hC0C0) | 32'hB;
                    1: d = (d & 32'hC0C0);
                    default: d = (d & 32'hC0C0) | 32'hF;
                endcase
            end else if (kind < 11) begin
                a = a + 8'(8'h40 + ch * 64);
                if ($urandom % 8 != 0) d = d % 12;
            end else if (kind < 13) begin
                a = a + 8'(8'h30 + ch * 64);
            end else if (kind == 13) begin
                d = ($urandom % 8 == 0) ? 32'h8000_0000 : (($urandom % 3 == 0) ? 32'h4000_0000 : 32'h0);
                a = 8'h00;
            end else begin
                a = a + 8'hA0;
            end
            if (r < 4) step(1, a, d, 1'($urandom % 2));
            else begin
                step(0, 8'h00, 32'h0, 1'($urandom % 2));
                rd(a, "R7 random read");
            end
            if (it % 500 == 0) check_all("random");
        end
        step(1, 8'h00, 32'h0, 0);
        check_all("final");
        summary();
    end

endmodule